// File: doc/BRIEF.md
# In-Order Retirement Buffer with Exception Flush

This block keeps results that are produced out of order and hands them to the architectural register file in program order. A front end claims one or two slots per cycle at the tail of a circular store. Each slot records the instruction address and the destination register. The slot index serves as the tag that the execution side later quotes when it returns a result together with an exception bit. The oldest slots are retired from the head, two at most per cycle. Retirement never skips a slot whose result is still missing.

While slots are being claimed, the block also resolves up to four source operands, two per claiming slot. It finds the youngest live slot that writes the named register. That slot yields either its finished value or its tag. When no slot matches, the operand is read from the internal register file. A second-slot source that names the destination of the first slot in the same cycle receives the first slot's tag. When the oldest slot carries an exception, the whole store is discarded, the faulting address is presented so fetch can restart there, and tag numbering restarts at zero.

Top module: `rob_core`

## Requirements
- R1: After reset the store is empty: no retirement, no flush, al_tag[0] is 0, and every operand lookup returns op_rdy=1 with value 0 from the cleared register file.
- R2: A granted slot 0 gets tag al_tag[0] (the tail index) and slot 1 gets al_tag[1] = tail+1 modulo DEPTH; the tail advances by the number of grants; slot 1 is granted only together with slot 0.
- R3: al_gnt[0] needs at least one free slot and al_gnt[1] at least two, counted from the occupancy at the start of the cycle (retirements in the same cycle do not free room).
- R4: A writeback on port w (wb_vld[w]) marks the slot wb_tag[w] done with wb_data[w] and wb_exc[w]; a writeback to a tag that holds no live slot has no effect.
- R5: Slot 0 of the retire port (cm_vld[0]) retires the head when it is done without exception, writing cm_data[0] to register cm_reg[0]; a head that is not done blocks all retirement, even when younger slots are done.
- R6: cm_vld[1] retires head+1 in the same cycle only when the head also retires and head+1 is done without exception; when both name the same register, the value of head+1 is the one kept.
- R7: A done head with its exception bit set raises fl_vld with fl_pc equal to that slot's address; in that cycle nothing retires, nothing is granted and writebacks are dropped; afterwards the store is empty and the next grant gets tag 0.
- R8: Operand lookup op_*[i] for source al_src[i] (i = 2*slot + k) picks the youngest live slot whose destination equals the source: if done, op_rdy=1, op_val=result, op_tag=0; if not, op_rdy=0, op_val=0, op_tag=its tag; with no match, op_rdy=1 and op_val is the register file entry. A lookup reflects state at the start of the cycle, not same-cycle writebacks.
- R9: For sources 2 and 3 (claiming slot 1), if slot 0 is granted in the same cycle and its destination equals the source, the lookup yields op_rdy=0, op_val=0 and op_tag=al_tag[0], overriding the store and the register file.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| al_req | input | 2 | Claim request per slot; bit 1 honoured only with bit 0 |
| al_pc | input | 2 x PC_W | Instruction address per claiming slot |
| al_dst | input | 2 x REG_W | Destination register per claiming slot |
| al_src | input | 4 x REG_W | Source registers; index 2*slot + operand |
| al_gnt | output | 2 | Claim granted per slot |
| al_tag | output | 2 x TAG_W | Tag a granted slot receives |
| op_rdy | output | 4 | Operand value is available |
| op_val | output | 4 x DATA_W | Operand value when available, else 0 |
| op_tag | output | 4 x TAG_W | Producer tag when not available, else 0 |
| wb_vld | input | 2 | Writeback strobe per port |
| wb_tag | input | 2 x TAG_W | Tag of the slot being completed |
| wb_exc | input | 2 | Exception bit of the returned result |
| wb_data | input | 2 x DATA_W | Returned result |
| cm_vld | output | 2 | Retirement per retire slot |
| cm_reg | output | 2 x REG_W | Register written by each retirement |
| cm_data | output | 2 x DATA_W | Value written by each retirement |
| fl_vld | output | 1 | Flush: head slot faulted |
| fl_pc | output | PC_W | Address of the faulting slot, 0 otherwise |

## Verification
The bench completes slots in reverse order so that a design letting a done younger slot retire past an unfinished head would write registers too early, and it retires two slots naming the same register so that reversed write priority leaves the older value behind. It fills the store, asks again in the cycle a slot retires, and expects no grant, which catches a design that counts same-cycle retirement as free room. It raises an exception at a head with live slots behind it and checks the restart address, the discarded operands and the tag restarting at zero. A stray writeback to an empty tag is later shown not to pre-complete the slot that reuses it, and lookups are checked for youngest-match priority, the same-cycle group dependency and the absence of same-cycle bypass.

// File: rtl/rob_pkg.sv
package rob_pkg;
  // Default geometry shared by the buffer and its checker.
  localparam int unsigned ROB_DEPTH_DEF = 8;
  localparam int unsigned ROB_NREG_DEF  = 8;
  localparam int unsigned ROB_DATA_DEF  = 16;
  localparam int unsigned ROB_PC_DEF    = 16;
  // Two claim slots, two operands each, two retire slots.
  localparam int unsigned ROB_SLOTS     = 2;
  localparam int unsigned ROB_SRCS      = 2 * ROB_SLOTS;
endpackage

// File: rtl/rob_arf.sv
module rob_arf #(
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             we,
  input  logic [1:0][REG_W-1:0]  waddr,
  input  logic [1:0][DATA_W-1:0] wdata,
  output logic [DATA_W-1:0]      regs [NREG]
);
  logic [DATA_W-1:0] regs_n [NREG];

  // Port 1 is the younger retirement and is applied last.
  always_comb begin
    regs_n = regs;
    for (int s = 0; s < 2; s++) begin
      if (we[s]) regs_n[waddr[s]] = wdata[s];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) regs <= '{default: '0};
    else if (|we) regs <= regs_n;
  end
endmodule

// File: rtl/rob_src_search.sv
module rob_src_search #(
  parameter int unsigned DEPTH  = 8,
  parameter int unsigned NREG   = 8,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic [REG_W-1:0]  src,
  input  logic [PTR_W-1:0]  head,
  input  logic              e_vld [DEPTH],
  input  logic              e_rdy [DEPTH],
  input  logic [REG_W-1:0]  e_dst [DEPTH],
  input  logic [DATA_W-1:0] e_res [DEPTH],
  input  logic [DATA_W-1:0] rf    [NREG],
  input  logic              grp_hit,
  input  logic [PTR_W-1:0]  grp_tag,
  output logic              rdy,
  output logic [DATA_W-1:0] val,
  output logic [PTR_W-1:0]  tag
);
  logic [PTR_W-1:0] idx;

  // Walk from oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    rdy = 1'b1;
    val = rf[src];
    tag = '0;
    idx = head;
    for (int j = 0; j < DEPTH; j++) begin
      idx = head + PTR_W'(j);
      if (e_vld[idx] && (e_dst[idx] == src)) begin
        rdy = e_rdy[idx];
        val = e_rdy[idx] ? e_res[idx] : '0;
        tag = e_rdy[idx] ? '0 : idx;
      end
    end
    if (grp_hit) begin
      rdy = 1'b0;
      val = '0;
      tag = grp_tag;
    end
  end
endmodule

// File: rtl/rob_core.sv
module rob_core
  import rob_pkg::*;
#(
  parameter int unsigned DEPTH  = ROB_DEPTH_DEF,
  parameter int unsigned NREG   = ROB_NREG_DEF,
  parameter int unsigned DATA_W = ROB_DATA_DEF,
  parameter int unsigned PC_W   = ROB_PC_DEF,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned REG_W = $clog2(NREG)
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [ROB_SLOTS-1:0]             al_req,
  input  logic [ROB_SLOTS-1:0][PC_W-1:0]   al_pc,
  input  logic [ROB_SLOTS-1:0][REG_W-1:0]  al_dst,
  input  logic [ROB_SRCS-1:0][REG_W-1:0]   al_src,
  output logic [ROB_SLOTS-1:0]             al_gnt,
  output logic [ROB_SLOTS-1:0][TAG_W-1:0]  al_tag,
  output logic [ROB_SRCS-1:0]              op_rdy,
  output logic [ROB_SRCS-1:0][DATA_W-1:0]  op_val,
  output logic [ROB_SRCS-1:0][TAG_W-1:0]   op_tag,
  input  logic [ROB_SLOTS-1:0]             wb_vld,
  input  logic [ROB_SLOTS-1:0][TAG_W-1:0]  wb_tag,
  input  logic [ROB_SLOTS-1:0]             wb_exc,
  input  logic [ROB_SLOTS-1:0][DATA_W-1:0] wb_data,
  output logic [ROB_SLOTS-1:0]             cm_vld,
  output logic [ROB_SLOTS-1:0][REG_W-1:0]  cm_reg,
  output logic [ROB_SLOTS-1:0][DATA_W-1:0] cm_data,
  output logic                             fl_vld,
  output logic [PC_W-1:0]                  fl_pc
);
  localparam int unsigned CNT_W = $clog2(DEPTH + 1);

  logic [TAG_W-1:0] head_q, head_n, tail_q, tail_n, head1, tail1;
  logic [CNT_W-1:0] cnt_q, cnt_n;

  logic              e_vld_q [DEPTH];
  logic              e_vld_n [DEPTH];
  logic              e_rdy_q [DEPTH];
  logic              e_rdy_n [DEPTH];
  logic              e_exc_q [DEPTH];
  logic              e_exc_n [DEPTH];
  logic [PC_W-1:0]   e_pc_q  [DEPTH];
  logic [PC_W-1:0]   e_pc_n  [DEPTH];
  logic [REG_W-1:0]  e_dst_q [DEPTH];
  logic [REG_W-1:0]  e_dst_n [DEPTH];
  logic [DATA_W-1:0] e_res_q [DEPTH];
  logic [DATA_W-1:0] e_res_n [DEPTH];
  logic [DATA_W-1:0] rf      [NREG];

  logic flush, c0, c1, g0, g1;

  // Head and grant decisions from the state at the start of the cycle.
  always_comb begin
    head1 = head_q + TAG_W'(1);
    tail1 = tail_q + TAG_W'(1);
    flush = e_vld_q[head_q] & e_rdy_q[head_q] & e_exc_q[head_q];
    c0    = e_vld_q[head_q] & e_rdy_q[head_q] & ~e_exc_q[head_q];
    c1    = c0 & e_vld_q[head1] & e_rdy_q[head1] & ~e_exc_q[head1];
    g0    = al_req[0] & ~flush & (cnt_q < CNT_W'(DEPTH));
    g1    = al_req[0] & al_req[1] & ~flush & (cnt_q <= CNT_W'(DEPTH - 2));
  end

  assign al_gnt     = {g1, g0};
  assign al_tag[0]  = tail_q;
  assign al_tag[1]  = tail1;
  assign cm_vld     = {c1, c0};
  assign cm_reg[0]  = e_dst_q[head_q];
  assign cm_reg[1]  = e_dst_q[head1];
  assign cm_data[0] = e_res_q[head_q];
  assign cm_data[1] = e_res_q[head1];
  assign fl_vld     = flush;
  assign fl_pc      = flush ? e_pc_q[head_q] : '0;

  // Next state: writeback, retirement and claim touch disjoint slots.
  always_comb begin
    e_vld_n = e_vld_q;
    e_rdy_n = e_rdy_q;
    e_exc_n = e_exc_q;
    e_pc_n  = e_pc_q;
    e_dst_n = e_dst_q;
    e_res_n = e_res_q;
    head_n  = head_q;
    tail_n  = tail_q;
    cnt_n   = cnt_q;
    if (flush) begin
      for (int i = 0; i < DEPTH; i++) begin
        e_vld_n[i] = 1'b0;
        e_rdy_n[i] = 1'b0;
        e_exc_n[i] = 1'b0;
      end
      head_n = '0;
      tail_n = '0;
      cnt_n  = '0;
    end else begin
      for (int w = 0; w < ROB_SLOTS; w++) begin
        if (wb_vld[w] && e_vld_q[wb_tag[w]]) begin
          e_rdy_n[wb_tag[w]] = 1'b1;
          e_exc_n[wb_tag[w]] = wb_exc[w];
          e_res_n[wb_tag[w]] = wb_data[w];
        end
      end
      if (c0) e_vld_n[head_q] = 1'b0;
      if (c1) e_vld_n[head1]  = 1'b0;
      if (g0) begin
        e_vld_n[tail_q] = 1'b1;
        e_rdy_n[tail_q] = 1'b0;
        e_exc_n[tail_q] = 1'b0;
        e_pc_n[tail_q]  = al_pc[0];
        e_dst_n[tail_q] = al_dst[0];
      end
      if (g1) begin
        e_vld_n[tail1] = 1'b1;
        e_rdy_n[tail1] = 1'b0;
        e_exc_n[tail1] = 1'b0;
        e_pc_n[tail1]  = al_pc[1];
        e_dst_n[tail1] = al_dst[1];
      end
      head_n = head_q + TAG_W'(c0) + TAG_W'(c1);
      tail_n = tail_q + TAG_W'(g0) + TAG_W'(g1);
      cnt_n  = cnt_q + CNT_W'(g0) + CNT_W'(g1) - CNT_W'(c0) - CNT_W'(c1);
    end
  end

  // Control state carries reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q  <= '0;
      tail_q  <= '0;
      cnt_q   <= '0;
      e_vld_q <= '{default: 1'b0};
      e_rdy_q <= '{default: 1'b0};
      e_exc_q <= '{default: 1'b0};
    end else begin
      head_q  <= head_n;
      tail_q  <= tail_n;
      cnt_q   <= cnt_n;
      e_vld_q <= e_vld_n;
      e_rdy_q <= e_rdy_n;
      e_exc_q <= e_exc_n;
    end
  end

  // Payload is only read behind a live valid bit, so it needs no reset.
  always_ff @(posedge clk) begin
    if (!flush) begin
      e_pc_q  <= e_pc_n;
      e_dst_q <= e_dst_n;
      e_res_q <= e_res_n;
    end
  end

  rob_arf #(.NREG(NREG), .DATA_W(DATA_W)) u_arf (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (cm_vld),
    .waddr (cm_reg),
    .wdata (cm_data),
    .regs  (rf)
  );

  for (genvar s = 0; s < ROB_SRCS; s++) begin : g_src
    logic grp;
    if (s >= ROB_SRCS / 2) begin : g_second
      assign grp = g0 && (al_src[s] == al_dst[0]);
    end else begin : g_first
      assign grp = 1'b0;
    end
    rob_src_search #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DATA_W)) u_search (
      .src     (al_src[s]),
      .head    (head_q),
      .e_vld   (e_vld_q),
      .e_rdy   (e_rdy_q),
      .e_dst   (e_dst_q),
      .e_res   (e_res_q),
      .rf      (rf),
      .grp_hit (grp),
      .grp_tag (tail_q),
      .rdy     (op_rdy[s]),
      .val     (op_val[s]),
      .tag     (op_tag[s])
    );
  end
endmodule

// File: rtl/rob_core_chk.sv
module rob_core_chk #(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned TAG_W = $clog2(DEPTH),
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [1:0]            al_gnt,
  input logic [1:0][TAG_W-1:0] al_tag,
  input logic [1:0]            cm_vld,
  input logic                  fl_vld
);
  // Occupancy seen from the ports only.
  logic [CNT_W-1:0] occ_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) occ_q <= '0;
    else if (fl_vld) occ_q <= '0;
    else occ_q <= occ_q + CNT_W'(al_gnt[0]) + CNT_W'(al_gnt[1])
                        - CNT_W'(cm_vld[0]) - CNT_W'(cm_vld[1]);
  end

  // R5
  commit_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cm_vld[1] |-> cm_vld[0]);

  // R7
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_vld |-> (cm_vld == 2'b00) && (al_gnt == 2'b00));

  // R7
  flush_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fl_vld |=> (al_tag[0] == '0) && !fl_vld);

  // R2
  grant_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    al_gnt[1] |-> al_gnt[0]);

  // R2
  tag_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_vld |=> al_tag[0] == $past(al_tag[0]) + TAG_W'($past(al_gnt[0]))
                                              + TAG_W'($past(al_gnt[1])));

  // R3
  no_overfill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (al_gnt[0] |-> occ_q < CNT_W'(DEPTH)) and
    (al_gnt[1] |-> occ_q <= CNT_W'(DEPTH - 2)));

  // R6
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cm_vld[0] |-> occ_q >= CNT_W'(1)) and (cm_vld[1] |-> occ_q >= CNT_W'(2)));
endmodule

bind rob_core rob_core_chk #(.DEPTH(DEPTH)) i_rob_core_chk (.*);

// File: tb/test_rob_core.sv
module test_rob_core;
  localparam int CLK_P = 10;
  localparam int DEPTH = 8;
  localparam int NREG  = 8;
  localparam int DW    = 16;
  localparam int PW    = 16;
  localparam int TW    = 3;
  localparam int RW    = 3;

  typedef struct packed {
    logic [RW-1:0] dst;
    logic [DW-1:0] data;
  } row_t;
  localparam int NROW = 6;
  localparam row_t ROWS [NROW] = '{
    '{3'd1, 16'h1111}, '{3'd2, 16'h2222}, '{3'd3, 16'h3333},
    '{3'd3, 16'h3A3A}, '{3'd4, 16'h4444}, '{3'd5, 16'h5555}};

  logic clk = 1'b0;
  logic rst_n;
  logic [1:0]         al_req;
  logic [1:0][PW-1:0] al_pc;
  logic [1:0][RW-1:0] al_dst;
  logic [3:0][RW-1:0] al_src;
  logic [1:0]         al_gnt;
  logic [1:0][TW-1:0] al_tag;
  logic [3:0]         op_rdy;
  logic [3:0][DW-1:0] op_val;
  logic [3:0][TW-1:0] op_tag;
  logic [1:0]         wb_vld;
  logic [1:0][TW-1:0] wb_tag;
  logic [1:0]         wb_exc;
  logic [1:0][DW-1:0] wb_data;
  logic [1:0]         cm_vld;
  logic [1:0][RW-1:0] cm_reg;
  logic [1:0][DW-1:0] cm_data;
  logic               fl_vld;
  logic [PW-1:0]      fl_pc;

  int n_chk = 0;
  int n_err = 0;
  logic [DW-1:0] model [NREG];

  always #(CLK_P / 2) clk = ~clk;

  rob_core #(.DEPTH(DEPTH), .NREG(NREG), .DATA_W(DW), .PC_W(PW)) i_rob_core (.*);

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%h exp=%h", what, act, exp);
    end
  endtask

  task automatic idle();
    al_req = '0; al_pc = '0; al_dst = '0; al_src = '0;
    wb_vld = '0; wb_tag = '0; wb_exc = '0; wb_data = '0;
  endtask

  // Move to the next low phase and clear all requests.
  task automatic nxt();
    @(negedge clk);
    idle();
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(CLK_P * 5000);
    n_err++;
    $display("FAIL watchdog act=%h exp=%h", 1, 0);
    finish_run();
  end

  initial begin
    for (int r = 0; r < NREG; r++) model[r] = '0;
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R1 cm_vld", 32'(cm_vld), 0);
    chk("R1 fl_vld", 32'(fl_vld), 0);
    chk("R1 al_tag0", 32'(al_tag[0]), 0);
    chk("R1 op_rdy", 32'(op_rdy), 32'hF);
    chk("R1 op_val", 32'(op_val[0]), 0);

    // Table walk: claim every row, finish them youngest first, retire in order.
    for (int i = 0; i < NROW; i++) begin
      nxt();
      al_req = 2'b01;
      al_dst[0] = ROWS[i].dst;
      al_pc[0] = 16'h0040 + 16'(4 * i);
      al_src[0] = 3'd3;
      #1;
      chk("R2 gnt", 32'(al_gnt), 32'b01);
      chk("R2 tag", 32'(al_tag[0]), 32'(i));
      if (i == 5) begin
        chk("R8 pending rdy", 32'(op_rdy[0]), 0);
        chk("R8 youngest tag", 32'(op_tag[0]), 3);
      end
    end
    for (int k = NROW - 1; k >= 0; k--) begin
      nxt();
      wb_vld = 2'b01;
      wb_tag[0] = TW'(k);
      wb_data[0] = ROWS[k].data;
      al_src[0] = 3'd3;
      #1;
      chk("R5 head blocks", 32'(cm_vld), 0);
      if (k == 2) begin
        chk("R8 done rdy", 32'(op_rdy[0]), 1);
        chk("R8 youngest val", 32'(op_val[0]), 32'h3A3A);
      end
    end
    for (int j = 0; j < NROW / 2; j++) begin
      nxt();
      #1;
      chk("R6 dual retire", 32'(cm_vld), 32'b11);
      chk("R5 reg0", 32'(cm_reg[0]), 32'(ROWS[2 * j].dst));
      chk("R5 data0", 32'(cm_data[0]), 32'(ROWS[2 * j].data));
      chk("R6 reg1", 32'(cm_reg[1]), 32'(ROWS[2 * j + 1].dst));
      chk("R6 data1", 32'(cm_data[1]), 32'(ROWS[2 * j + 1].data));
    end
    for (int i = 0; i < NROW; i++) model[ROWS[i].dst] = ROWS[i].data;
    nxt();
    al_src = {3'd4, 3'd3, 3'd2, 3'd1};
    #1;
    for (int s = 0; s < 4; s++) begin
      chk("R8 regfile rdy", 32'(op_rdy[s]), 1);
      chk("R6 regfile val", 32'(op_val[s]), 32'(model[s + 1]));
    end

    // Fill to capacity starting at tag 6, wrapping.
    for (int f = 0; f < 4; f++) begin
      nxt();
      al_req = 2'b11;
      al_pc[0] = 16'hC000 + 16'(2 * f);
      al_pc[1] = 16'hC001 + 16'(2 * f);
      al_dst[0] = (f == 0) ? 3'd1 : 3'd4;
      al_dst[1] = (f == 0) ? 3'd2 : 3'd5;
      #1;
      chk("R2 pair gnt", 32'(al_gnt), 32'b11);
      chk("R2 wrap tag0", 32'(al_tag[0]), 32'((6 + 2 * f) % DEPTH));
      chk("R2 wrap tag1", 32'(al_tag[1]), 32'((7 + 2 * f) % DEPTH));
    end
    nxt();
    al_req = 2'b11;
    wb_vld = 2'b01; wb_tag[0] = 3'd6; wb_data[0] = 16'h6666;
    #1;
    chk("R3 full", 32'(al_gnt), 0);
    nxt();
    al_req = 2'b11;
    #1;
    chk("R5 single retire", 32'(cm_vld), 32'b01);
    chk("R5 data", 32'(cm_data[0]), 32'h6666);
    chk("R3 no same-cycle room", 32'(al_gnt), 0);
    nxt();
    al_req = 2'b11;
    al_pc[0] = 16'hC008; al_dst[0] = 3'd3;
    wb_vld = 2'b11;
    wb_tag[0] = 3'd7; wb_exc[0] = 1'b1; wb_data[0] = 16'h0;
    wb_tag[1] = 3'd0; wb_data[1] = 16'h0101;
    #1;
    chk("R3 one free", 32'(al_gnt), 32'b01);
    chk("R3 tag", 32'(al_tag[0]), 6);
    nxt();
    al_req = 2'b11;
    #1;
    chk("R7 flush", 32'(fl_vld), 1);
    chk("R7 flush pc", 32'(fl_pc), 32'hC001);
    chk("R7 no retire", 32'(cm_vld), 0);
    chk("R7 no grant", 32'(al_gnt), 0);
    nxt();
    al_src[0] = 3'd1; al_src[1] = 3'd3; al_src[2] = 3'd2;
    wb_vld = 2'b01; wb_tag[0] = 3'd3; wb_data[0] = 16'hDEAD;
    #1;
    chk("R7 flush gone", 32'(fl_vld), 0);
    chk("R7 tag restart", 32'(al_tag[0]), 0);
    chk("R7 r1 from file", 32'(op_val[0]), 32'h6666);
    chk("R7 r3 discarded", 32'(op_val[1]), 32'h3A3A);
    chk("R7 r2 discarded", 32'({op_rdy[2], op_val[2]}), 32'h12222);
    nxt();
    al_req = 2'b11;
    al_dst[0] = 3'd6; al_dst[1] = 3'd7;
    al_src[0] = 3'd6; al_src[2] = 3'd6;
    #1;
    chk("R7 first tags", 32'({al_gnt, al_tag[1], al_tag[0]}), 32'({2'b11, 3'd1, 3'd0}));
    chk("R9 group rdy", 32'(op_rdy[2]), 0);
    chk("R9 group tag", 32'(op_tag[2]), 0);
    chk("R9 slot0 unaffected", 32'({op_rdy[0], op_val[0]}), 32'h10000);
    nxt();
    al_req = 2'b11;
    al_dst[0] = 3'd7; al_dst[1] = 3'd7;
    #1;
    chk("R2 tags", 32'({al_tag[1], al_tag[0]}), 32'({3'd3, 3'd2}));
    nxt();
    al_src[0] = 3'd7;
    wb_vld = 2'b01; wb_tag[0] = 3'd3; wb_data[0] = 16'h7777;
    #1;
    chk("R4 stray ignored", 32'(op_rdy[0]), 0);
    chk("R8 no bypass tag", 32'(op_tag[0]), 3);
    nxt();
    al_src[0] = 3'd7; al_src[1] = 3'd6;
    #1;
    chk("R4 wb value", 32'({op_rdy[0], op_val[0]}), 32'h17777);
    chk("R8 pending r6", 32'({op_rdy[1], op_tag[1]}), 32'({1'b0, 3'd0}));
    chk("R5 wait head", 32'(cm_vld), 0);
    finish_run();
  end
endmodule